// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block produces the SCL timing for an I2C master. A configuration word supplies three fields: a low-phase divider, a high-phase divider and a power-of-two prescale exponent. A fixed offset, chosen at build time, is added to every phase. While enabled, the block alternates between a low phase and a high phase. It drives a level for SCL and gives a one-cycle tick at every phase boundary, so that the controller around it can time data and start/stop changes.

Each phase lasts `div * 2^exp + OFFSET` input clocks. With equal dividers, the SCL frequency is therefore the input clock divided by `2 * (div * 2^exp + OFFSET)`. The high phase only counts clocks in which the sampled bus line is high, so a target that holds SCL low stretches the phase. The controller can pause the generator, which freezes it in place. It can also disable it, which parks SCL high and clears the count. A later enable starts a fresh period.

A new configuration is written into a shadow copy. It is used from the next phase boundary on, so a running phase is never cut short or lengthened by a write. Typical settings give 100 kHz, and settings up to 400 kHz are supported.

Top module: `scl_wavegen`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `enable` low, `scl_out` is 1 and both ticks are 0.
- R2: When `enable` is sampled high while the generator is idle and `hold` is low, `scl_out` goes to 0 and `tick_fall` pulses in the next cycle.
- R3: The configuration word holds the low divider in bits [7:0], the high divider in bits [15:8] and the exponent in bits [18:16]. The low phase lasts exactly `low_div * 2^exp + OFFSET` cycles (OFFSET = 4), counted from the `tick_fall` cycle to the `tick_rise` cycle.
- R4: With `scl_in` following `scl_out`, the high phase lasts `high_div * 2^exp + OFFSET` cycles, counted from `tick_rise` to the next `tick_fall`. A divider of 0 gives a phase of OFFSET cycles.
- R5: During the high phase, clock edges at which `scl_in` is sampled low do not advance the count. `scl_out` stays 1 and `tick_fall` is delayed by exactly that number of cycles.
- R6: An exponent above the build maximum `EXP_MAX` is treated as `EXP_MAX`.
- R7: A word captured by `load` is used only from the next phase boundary (a start, a rise or a fall). The phase in progress keeps its length.
- R8: While `enable` and `hold` are both high, the count, the phase and `scl_out` are frozen, and no tick occurs. Each held cycle lengthens the current phase by one cycle.
- R9: Dropping `enable` returns `scl_out` to 1 in the next cycle, with no tick, and clears the count. A later start gives a full low phase.
- R10: `tick_rise` and `tick_fall` are single-cycle pulses that never coincide. `tick_rise` appears exactly in the cycle in which `scl_out` changes from 0 to 1, and `tick_fall` in the cycle in which it changes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all phase lengths count |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run the generator; low parks SCL high and clears the count |
| hold | input | 1 | Freeze the generator in its current state |
| load | input | 1 | Capture `cfg_word` into the shadow configuration |
| cfg_word | input | 2*DIV_W+EXP_W | Exponent, high divider and low divider, packed from the top down |
| scl_in | input | 1 | Sampled (already synchronised) SCL bus level |
| scl_out | output | 1 | SCL level to drive: 0 pulls low, 1 releases |
| tick_rise | output | 1 | One-cycle pulse at a low-to-high boundary |
| tick_fall | output | 1 | One-cycle pulse at a high-to-low boundary |

## Verification
The first tick is due one cycle after the edge that samples `enable` high. Every later tick is due a computed number of cycles after the tick before it: the phase length, plus one cycle for each edge that is held or stretched. The disable result is due one cycle after the sampling edge. The bench keeps a free-running cycle count and pushes each expected tick, with its exact cycle number, into a queue before the stimulus that causes it. A monitor samples on the falling clock edge and compares the kind, the cycle and the SCL level of every tick it pops. Level checks during a hold, a stretch or a disable are taken at fixed cycles that lie inside the phase under test.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [2*DIV_W+EXP_W-1:0] cfg_word,
  input  logic                     apply,
  output logic [DIV_W-1:0]         lo_div,
  output logic [DIV_W-1:0]         hi_div,
  output logic [EXP_W-1:0]         exp_val
);

  localparam int CFG_W = 2*DIV_W + EXP_W;
  localparam logic [EXP_W-1:0] EXP_CAP =
    (EXP_MAX >= (2**EXP_W)) ? {EXP_W{1'b1}} : EXP_W'(EXP_MAX);

  logic [DIV_W-1:0] pend_lo_q, pend_hi_q, act_lo_q, act_hi_q;
  logic [EXP_W-1:0] pend_exp_q, act_exp_q;
  logic [EXP_W-1:0] exp_field, exp_capped;

  // exponent is limited when written, so the shadow copy never holds an illegal value
  always_comb begin
    exp_field  = cfg_word[CFG_W-1:2*DIV_W];
    exp_capped = (exp_field > EXP_CAP) ? EXP_CAP : exp_field;
  end

  // shadow copy, written by the controller at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lo_q  <= '0;
      pend_hi_q  <= '0;
      pend_exp_q <= '0;
    end else if (load) begin
      pend_lo_q  <= cfg_word[DIV_W-1:0];
      pend_hi_q  <= cfg_word[2*DIV_W-1:DIV_W];
      pend_exp_q <= exp_capped;
    end
  end

  // active copy, refreshed only at phase boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo_q  <= '0;
      act_hi_q  <= '0;
      act_exp_q <= '0;
    end else if (apply) begin
      act_lo_q  <= pend_lo_q;
      act_hi_q  <= pend_hi_q;
      act_exp_q <= pend_exp_q;
    end
  end

  assign lo_div  = act_lo_q;
  assign hi_div  = act_hi_q;
  assign exp_val = act_exp_q;

endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int DIV_W  = 8,
  parameter int EXP_W  = 3,
  parameter int OFFSET = 4,
  parameter int LEN_W  = 16
) (
  input  logic [DIV_W-1:0] div,
  input  logic [EXP_W-1:0] exp_val,
  output logic [LEN_W-1:0] len
);

  logic [LEN_W-1:0] scaled, total;

  always_comb begin
    scaled = LEN_W'(div) << exp_val;
    total  = scaled + LEN_W'(OFFSET);
    // a zero-length phase would never end; one cycle is the floor
    len    = (total == '0) ? LEN_W'(1) : total;
  end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_wavegen_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hold,
  input  logic             scl_in,
  input  logic [LEN_W-1:0] len_low,
  input  logic [LEN_W-1:0] len_high,
  output phase_e           phase,
  output logic             scl_out,
  output logic             tick_rise,
  output logic             tick_fall,
  output logic             apply
);

  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             scl_q, scl_d;
  logic             rise_q, rise_d, fall_q, fall_d;
  logic             adv_en;
  logic             low_done, high_done;

  assign adv_en    = !enable || !hold;
  assign low_done  = (cnt_q == len_low  - LEN_W'(1));
  assign high_done = (cnt_q == len_high - LEN_W'(1));

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    scl_d  = scl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    apply  = 1'b0;
    if (!enable) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      scl_d = 1'b1;
    end else if (!hold) begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_LOW;
          cnt_d  = '0;
          scl_d  = 1'b0;
          fall_d = 1'b1;
          apply  = 1'b1;
        end
        PH_LOW: begin
          if (low_done) begin
            ph_d   = PH_HIGH;
            cnt_d  = '0;
            scl_d  = 1'b1;
            rise_d = 1'b1;
            apply  = 1'b1;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          // count only once the line is seen high: stretching lengthens the phase
          if (scl_in) begin
            if (high_done) begin
              ph_d   = PH_LOW;
              cnt_d  = '0;
              scl_d  = 1'b0;
              fall_d = 1'b1;
              apply  = 1'b1;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
          scl_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      scl_q <= 1'b1;
    end else if (adv_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      scl_q <= scl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign phase     = ph_q;
  assign scl_out   = scl_q;
  assign tick_rise = rise_q;
  assign tick_fall = fall_q;

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 7,
  parameter int OFFSET  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     hold,
  input  logic                     load,
  input  logic [2*DIV_W+EXP_W-1:0] cfg_word,
  input  logic                     scl_in,
  output logic                     scl_out,
  output logic                     tick_rise,
  output logic                     tick_fall
);

  localparam int LEN_W  = DIV_W + (2**EXP_W);
  localparam int N_PHAS = 2;

  logic             rst_int_n;
  logic             apply;
  logic [DIV_W-1:0] lo_div, hi_div;
  logic [EXP_W-1:0] exp_val;
  logic [DIV_W-1:0] div_sel [N_PHAS];
  logic [LEN_W-1:0] len_sel [N_PHAS];
  phase_e           phase_q;

  scl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  scl_cfg_regs #(
    .DIV_W   (DIV_W),
    .EXP_W   (EXP_W),
    .EXP_MAX (EXP_MAX)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .cfg_word (cfg_word),
    .apply    (apply),
    .lo_div   (lo_div),
    .hi_div   (hi_div),
    .exp_val  (exp_val)
  );

  assign div_sel[0] = lo_div;
  assign div_sel[1] = hi_div;

  // one length calculator per phase, both sharing the exponent
  for (genvar gi = 0; gi < N_PHAS; gi++) begin : g_len
    scl_phase_len #(
      .DIV_W  (DIV_W),
      .EXP_W  (EXP_W),
      .OFFSET (OFFSET),
      .LEN_W  (LEN_W)
    ) u_len (
      .div     (div_sel[gi]),
      .exp_val (exp_val),
      .len     (len_sel[gi])
    );
  end

  scl_phase_ctr #(
    .LEN_W (LEN_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .hold      (hold),
    .scl_in    (scl_in),
    .len_low   (len_sel[0]),
    .len_high  (len_sel[1]),
    .phase     (phase_q),
    .scl_out   (scl_out),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .apply     (apply)
  );

endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk
  import scl_wavegen_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   enable,
  input logic   hold,
  input logic   scl_in,
  input logic   scl_out,
  input logic   tick_rise,
  input logic   tick_fall,
  input phase_e phase
);

  assert_ticks_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_rise && tick_fall));

  assert_rise_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> (scl_out && !$past(scl_out)));

  assert_fall_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> (!scl_out && $past(scl_out)));

  // R1 and R9: a disabled cycle is followed by a parked, silent cycle
  assert_disable_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_out && !tick_rise && !tick_fall));

  assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hold) |=> ($stable(scl_out) && !tick_rise && !tick_fall));

  assert_stretch_blocks_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_HIGH && !scl_in) |=> (scl_out && !tick_fall));

endmodule

bind scl_wavegen scl_wavegen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .hold      (hold),
  .scl_in    (scl_in),
  .scl_out   (scl_out),
  .tick_rise (tick_rise),
  .tick_fall (tick_fall),
  .phase     (phase_q)
);

// File: tb/tb_scl_wavegen.sv
module tb_scl_wavegen;

  localparam int CLK_PERIOD = 10;
  localparam int TB_EXP_MAX = 3;
  localparam int TB_OFFSET  = 4;

  typedef struct {
    bit rise;
    int at;
  } ev_t;

  logic        clk;
  logic        rst_n;
  logic        enable, hold, load, stretch;
  logic [18:0] cfg_word;
  logic        scl_in, scl_out, tick_rise, tick_fall;

  int  cyc   = 0;
  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  ev_t exp_q[$];

  scl_wavegen #(
    .DIV_W   (8),
    .EXP_W   (3),
    .EXP_MAX (TB_EXP_MAX),
    .OFFSET  (TB_OFFSET)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .hold      (hold),
    .load      (load),
    .cfg_word  (cfg_word),
    .scl_in    (scl_in),
    .scl_out   (scl_out),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  // the bus line follows the drive unless a target stretches it low
  assign scl_in = scl_out & ~stretch;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // phase length from the requirements: div * 2^min(exp, EXP_MAX) + OFFSET
  function automatic int plen(input int dv, input int ex);
    int e = (ex > TB_EXP_MAX) ? TB_EXP_MAX : ex;
    return (dv << e) + TB_OFFSET;
  endfunction

  task automatic push_ev(input bit rise, input int at);
    ev_t e;
    e.rise = rise;
    e.at   = at;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic load_cfg(input int lo, input int hi, input int ex);
    cfg_word = {3'(ex), 8'(hi), 8'(lo)};
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic stop_at(input int t);
    wait_until(t);
    enable = 1'b0;
    wait_until(t + 1);
    check(scl_out == 1'b1, "R9 scl parked after disable", scl_out, 1);
    repeat (3) @(negedge clk);
  endtask

  // monitor: every tick must match the head of the scoreboard
  always @(negedge clk) begin
    ev_t e;
    if (rst_n && (tick_rise || tick_fall)) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R10 unexpected tick: actual rise=%0d fall=%0d expected none (cycle %0d)",
                 tick_rise, tick_fall, cyc);
      end else begin
        e = exp_q.pop_front();
        check(tick_rise == e.rise, "R10 tick kind", int'(tick_rise), int'(e.rise));
        check(cyc == e.at, "R3 R4 tick cycle", cyc, e.at);
        check(scl_out == e.rise, "R10 level at tick", int'(scl_out), int'(e.rise));
      end
    end
  end

  initial begin
    int c0;
    int c1;
    int lo_a;
    int hi_a;
    int lo_b;
    int hi_b;
    rst_n = 1'b0; enable = 1'b0; hold = 1'b0; load = 1'b0; stretch = 1'b0;
    cfg_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle state after reset
    check(scl_out == 1'b1, "R1 reset scl level", scl_out, 1);
    check(!tick_rise && !tick_fall, "R1 reset ticks", int'(tick_rise || tick_fall), 0);

    // R2 R3 R4: basic running, low 3 high 2 exp 1 -> 10 / 8
    lo_a = plen(3, 1);
    hi_a = plen(2, 1);
    load_cfg(3, 2, 1);
    check(scl_out == 1'b1, "R1 load while idle keeps scl high", scl_out, 1);
    c0 = cyc;
    push_ev(0, c0 + 1);
    push_ev(1, c0 + 1 + lo_a);
    push_ev(0, c0 + 1 + lo_a + hi_a);
    push_ev(1, c0 + 1 + 2*lo_a + hi_a);
    push_ev(0, c0 + 1 + 2*lo_a + 2*hi_a);
    enable = 1'b1;
    wait_until(c0 + 1);
    check(scl_out == 1'b0, "R2 scl low one cycle after enable", scl_out, 0);
    wait_until(c0 + 5);
    check(scl_out == 1'b0, "R3 scl low inside low phase", scl_out, 0);
    wait_until(c0 + 15);
    check(scl_out == 1'b1, "R4 scl high inside high phase", scl_out, 1);
    stop_at(c0 + 40);

    // R7: new word loaded during the low phase takes over at the rise
    lo_b = plen(1, 0);
    hi_b = plen(5, 0);
    c0 = cyc;
    push_ev(0, c0 + 1);
    push_ev(1, c0 + 1 + lo_a);
    push_ev(0, c0 + 1 + lo_a + hi_b);
    push_ev(1, c0 + 1 + lo_a + hi_b + lo_b);
    push_ev(0, c0 + 1 + lo_a + 2*hi_b + lo_b);
    enable = 1'b1;
    wait_until(c0 + 3);
    load_cfg(1, 5, 0);
    stop_at(c0 + 36);

    // R6: exponent 6 clamps to the build maximum of 3 -> 12 / 12
    load_cfg(1, 1, 6);
    c0 = cyc;
    push_ev(0, c0 + 1);
    push_ev(1, c0 + 13);
    push_ev(0, c0 + 25);
    enable = 1'b1;
    stop_at(c0 + 27);

    // R5: stretch the high phase for 5 edges, low 2 high 2 exp 0 -> 6 / 6
    load_cfg(2, 2, 0);
    c0 = cyc;
    push_ev(0, c0 + 1);
    push_ev(1, c0 + 7);
    push_ev(0, c0 + 7 + 5 + 6);
    push_ev(1, c0 + 7 + 5 + 12);
    enable = 1'b1;
    wait_until(c0 + 7);
    stretch = 1'b1;
    wait_until(c0 + 10);
    check(scl_out == 1'b1, "R5 drive stays released while stretched", scl_out, 1);
    wait_until(c0 + 12);
    stretch = 1'b0;
    stop_at(c0 + 26);

    // R8: hold 4 edges inside the low phase
    c0 = cyc;
    push_ev(0, c0 + 1);
    push_ev(1, c0 + 11);
    push_ev(0, c0 + 17);
    enable = 1'b1;
    wait_until(c0 + 2);
    hold = 1'b1;
    wait_until(c0 + 5);
    check(scl_out == 1'b0, "R8 level frozen during hold", scl_out, 0);
    wait_until(c0 + 6);
    hold = 1'b0;
    stop_at(c0 + 19);

    // R9: disable mid-low, restart yields a full low phase
    c0 = cyc;
    push_ev(0, c0 + 1);
    enable = 1'b1;
    stop_at(c0 + 4);
    c1 = cyc;
    push_ev(0, c1 + 1);
    push_ev(1, c1 + 7);
    enable = 1'b1;
    stop_at(c1 + 9);

    // R4: zero dividers give OFFSET-only phases (exp 5 clamps to 3, still 0)
    load_cfg(0, 0, 5);
    c0 = cyc;
    push_ev(0, c0 + 1);
    push_ev(1, c0 + 5);
    push_ev(0, c0 + 9);
    push_ev(1, c0 + 13);
    enable = 1'b1;
    stop_at(c0 + 14);

    // R1: idle after all runs, scoreboard fully consumed
    repeat (5) @(negedge clk);
    check(scl_out == 1'b1, "R1 idle level at end", scl_out, 1);
    check(exp_q.size() == 0, "R10 all expected ticks seen", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion (cycle %0d)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule